// File: doc/BRIEF.md
# Frame Accept Arbiter with External Reject Window

This block makes the final keep-or-drop call for each received frame. It combines four inputs: the result of an internal address filter, a promiscuous-mode setting, a setting that allows frames shorter than the minimum length, and an active-low reject line driven by external lookup logic. The receive path drives a frame-active qualifier. It also drives a one-cycle tick for every bit received after the start-of-frame delimiter.

The reject line is asynchronous to the system clock, so it is synchronised first. A low level only counts once it has lasted a minimum time, measured in system clocks. A qualified reject is honoured only while the number of received bits is still below the window limit, which is 512 bit times by default. The decision is computed when the frame-active qualifier drops. It is presented on `keep` together with a one-cycle `dec_valid` strobe, and `keep` holds its value until the next decision. The block works only while its run enable is high, whatever the state of the receiver and transmitter.

Top module: `frame_accept_arb`

## Requirements
- R1: While reset is held and immediately after it is released, `keep` and `dec_valid` are 0.
- R2: With `run_en` high, `dec_valid` is high for exactly one clock: the clock that follows the first rising edge at which `rx_active` is sampled low after having been high. `keep` carries the decision during that clock.
- R3: If `promisc` is 1 and the frame is not dropped for length (R8), the frame is kept whatever `ext_rej_n` does.
- R4: If `addr_hit` is 1 when the frame ends and the frame is not dropped for length, the frame is kept whatever `ext_rej_n` does.
- R5: If `promisc` and `addr_hit` are both 0, a qualified low on `ext_rej_n` while fewer than 512 bit ticks have been counted in the frame causes `keep`=0. Without such a low, `keep`=1.
- R6: A reject that qualifies only after 512 bit ticks have been counted has no effect, and the frame is kept.
- R7: At 100 MHz, `ext_rej_n` held low for 15 or more consecutive clocks (150 ns) qualifies as a reject. A low lasting 14 clocks or fewer never rejects.
- R8: A frame with fewer than 512 bit ticks is dropped (`keep`=0) when `runt_ok` is 0, even in promiscuous mode. When `runt_ok` is 1, it is judged like a full frame, with the reject window closing at the frame's end. A frame of exactly 512 ticks counts as full length.
- R9: While `run_en` is 0, no `dec_valid` strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Block operates while high |
| rx_active | input | 1 | High for the frame, from the delimiter to the last bit |
| bit_tick | input | 1 | One-clock pulse per received bit while rx_active is high |
| addr_hit | input | 1 | Internal address filter matched; sampled at frame end |
| promisc | input | 1 | Promiscuous mode |
| runt_ok | input | 1 | Keep frames shorter than the minimum length |
| ext_rej_n | input | 1 | Asynchronous active-low external reject |
| keep | output | 1 | 1 = frame kept, 0 = dropped |
| dec_valid | output | 1 | One-clock strobe marking a new decision |

## Verification
The hardest case to reach from the ports is a reject that lands right at an edge. This covers a low that falls one clock short of or exactly at the qualification length, a low near the 512-bit window boundary, and a short frame that ends just after its reject. Directed frames place 14-clock and 15-clock lows and late lows just past the window. Randomly sized frames, some short and some long, put reject pulses in zones chosen so that the expected result is unambiguous, and they mix these with random filter and mode settings.

// File: rtl/frame_accept_arb.sv
module frame_accept_arb #(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int MIN_LOW_PS    = 150000,
  parameter int WIN_BITS      = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic rx_active,
  input  logic bit_tick,
  input  logic addr_hit,
  input  logic promisc,
  input  logic runt_ok,
  input  logic ext_rej_n,
  output logic keep,
  output logic dec_valid
);
  localparam int LOW_CLKS = (MIN_LOW_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int LW = $clog2(LOW_CLKS + 1);
  localparam int BW = $clog2(WIN_BITS + 1);

  logic [1:0]    rej_sync;
  logic [LW-1:0] low_cnt;
  logic [BW-1:0] bit_cnt;
  logic          act_d;
  logic          rej_seen;

  wire rej_q    = (low_cnt == LW'(LOW_CLKS));
  wire start    = run_en & rx_active & ~act_d;
  wire ending   = run_en & act_d & ~rx_active;
  wire win_open = (bit_cnt < BW'(WIN_BITS));
  wire verdict  = (~win_open | runt_ok) & (promisc | addr_hit | ~rej_seen);

  always_ff @(posedge clk) begin
    if (!rst_n) rej_sync <= 2'b11;
    else        rej_sync <= {rej_sync[0], ext_rej_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rej_sync[1]) low_cnt <= '0;
    else if (!rej_q)           low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_d    <= 1'b0;
      bit_cnt  <= '0;
      rej_seen <= 1'b0;
    end else begin
      act_d <= run_en & rx_active;
      if (start) begin
        bit_cnt  <= bit_tick ? BW'(1) : '0;
        rej_seen <= rej_q;
      end else if (run_en & rx_active) begin
        if (bit_tick && win_open) bit_cnt <= bit_cnt + 1'b1;
        if (win_open && rej_q)    rej_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep      <= 1'b0;
      dec_valid <= 1'b0;
    end else begin
      dec_valid <= ending;
      if (ending) keep <= verdict;
    end
  end
endmodule

module frame_accept_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic rx_active,
  input logic addr_hit,
  input logic promisc,
  input logic runt_ok,
  input logic keep,
  input logic dec_valid
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) dec_valid |=> !dec_valid); // R2
  AST_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) dec_valid |-> (!$past(rx_active) && $past(rx_active, 2))); // R2
  AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (dec_valid && $past(promisc) && $past(runt_ok)) |-> keep); // R3
  AST_HIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (dec_valid && $past(addr_hit) && $past(runt_ok)) |-> keep); // R4
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !$past(run_en) |-> !dec_valid); // R9
endmodule

bind frame_accept_arb frame_accept_arb_chk chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .rx_active(rx_active),
  .addr_hit(addr_hit), .promisc(promisc), .runt_ok(runt_ok),
  .keep(keep), .dec_valid(dec_valid)
);

// File: tb/frame_accept_arb_tb.sv
module frame_accept_arb_tb_top;
  logic clk = 1'b0;
  logic rst_n, run_en, rx_active, bit_tick, addr_hit, promisc, runt_ok, ext_rej_n;
  logic keep, dec_valid;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frame_accept_arb dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .rx_active(rx_active),
    .bit_tick(bit_tick), .addr_hit(addr_hit), .promisc(promisc),
    .runt_ok(runt_ok), .ext_rej_n(ext_rej_n), .keep(keep), .dec_valid(dec_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic model_keep(input int nbits, input logic r_ok, input logic pr,
                                      input logic hit, input logic rej_eff);
    return (nbits >= 512 || r_ok) && (pr || hit || !rej_eff);
  endfunction

  // rs: clock index of the reject low inside the frame (-1 = none), rl: its length in clocks
  task automatic run_frame(input int nbits, input int rs, input int rl, input logic en,
                           input logic exp_keep, input string req);
    int fc;
    fc = nbits * 2;
    for (int c = 0; c < fc; c++) begin
      @(negedge clk);
      rx_active = 1'b1;
      bit_tick  = (c % 2 == 0);
      ext_rej_n = !(rs >= 0 && c >= rs && c < rs + rl);
    end
    @(negedge clk);
    rx_active = 1'b0; bit_tick = 1'b0; ext_rej_n = 1'b1;
    @(negedge clk);
    if (en) begin
      check(dec_valid === 1'b1, {req, " strobe"}, dec_valid, 1);
      check(keep === exp_keep, {req, " keep"}, keep, exp_keep);
    end else begin
      check(dec_valid === 1'b0, {req, " no strobe"}, dec_valid, 0);
    end
    @(negedge clk);
    check(dec_valid === 1'b0, "R2 strobe width", dec_valid, 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; run_en = 1'b1; rx_active = 1'b0; bit_tick = 1'b0;
    addr_hit = 1'b0; promisc = 1'b0; runt_ok = 1'b0; ext_rej_n = 1'b1;
    repeat (4) @(negedge clk);
    check(keep === 1'b0 && dec_valid === 1'b0, "R1 in reset", {keep, dec_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(keep === 1'b0 && dec_valid === 1'b0, "R1 after reset", {keep, dec_valid}, 0);

    run_frame(600, -1, 0, 1'b1, 1'b1, "R5 clean frame");
    run_frame(600, 100, 30, 1'b1, 1'b0, "R5 early reject");
    run_frame(600, 100, 14, 1'b1, 1'b1, "R7 14-clock glitch");
    run_frame(600, 100, 15, 1'b1, 1'b0, "R7 15-clock low");
    run_frame(600, 1050, 40, 1'b1, 1'b1, "R6 late reject");
    promisc = 1'b1;
    run_frame(600, 100, 30, 1'b1, 1'b1, "R3 promisc");
    run_frame(200, -1, 0, 1'b1, 1'b0, "R8 runt dropped in promisc");
    promisc = 1'b0; addr_hit = 1'b1;
    run_frame(600, 100, 30, 1'b1, 1'b1, "R4 address hit");
    addr_hit = 1'b0;
    run_frame(511, -1, 0, 1'b1, 1'b0, "R8 511 bits");
    run_frame(512, -1, 0, 1'b1, 1'b1, "R8 512 bits");
    runt_ok = 1'b1;
    run_frame(200, 340, 20, 1'b1, 1'b0, "R8 runt reject before end");
    run_frame(200, -1, 0, 1'b1, 1'b1, "R8 runt kept");
    run_en = 1'b0;
    run_frame(300, -1, 0, 1'b0, 1'b0, "R9 disabled");
    run_en = 1'b1;

    for (int i = 0; i < 30; i++) begin
      int nb, rs, rl, lim, mode;
      logic pr, hit, rok, eff;
      nb  = ($urandom % 2) ? 520 + int'($urandom % 180) : 100 + int'($urandom % 300);
      pr  = ($urandom % 4) == 0;
      hit = ($urandom % 4) == 0;
      rok = $urandom % 2;
      rl  = ($urandom % 2) ? 1 + int'($urandom % 14) : 15 + int'($urandom % 26);
      lim = (nb * 2 < 1000) ? nb * 2 : 1000;
      mode = $urandom % 3;
      rs = -1; eff = 1'b0;
      if (mode == 0 && lim > 60) begin
        rs = int'($urandom % (lim - 50));
        if (rs > 900) rs = 900;
        eff = (rl >= 15);
      end else if (mode == 1 && nb * 2 > 1100) begin
        rs = 1040 + int'($urandom % (nb * 2 - 1080));
      end
      promisc = pr; addr_hit = hit; runt_ok = rok;
      run_frame(nb, rs, rl, 1'b1, model_keep(nb, rok, pr, hit, eff), "R5 random frame");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule